// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block produces the two early-warning flags for one queue. The write side supplies its write pointer in the write clock domain and the read side supplies its read pointer in the read clock domain. Each pointer is one bit wider than the queue address, so the difference of the two is the number of stored words. Almost-empty is raised when few words remain to be read. Almost-full is raised when little free space remains for writing. Each flag has its own offset, which sets its threshold.

Two configuration pins are sampled while reset is held. A 2-bit select picks one default offset, and that value is loaded into both thresholds. A timing-mode pin picks between two flag modes. In registered mode each flag is computed from a synchronised copy of the far pointer and held in a flop of its own clock domain. In direct mode each flag is a combinational decode of the raw pointer inputs. A load port in the write domain can replace either offset. It accepts a write only when the queue is idle.

The offset controller is a three-state machine. It sits in `OFS_CAPTURE` while reset is low, loading the defaults from the select pins. It moves from `OFS_CAPTURE` to `OFS_DEFAULT` on the first clock after reset is released. It moves from `OFS_DEFAULT` to `OFS_CUSTOM` on the first accepted offset load. It stays in `OFS_CUSTOM` for every later load. From any state it returns to `OFS_CAPTURE` when reset is asserted.

Top module: `pafu_flags`

## Requirements
- R1: The offset select sampled during reset sets both thresholds. Code 2'b00 gives 1023, 2'b01 gives 127, 2'b10 gives 63 and 2'b11 gives 7.
- R2: While reset is low, almost-empty is high and almost-full is low, whatever the pointers hold.
- R3: When the mode pin is high during reset, almost-empty is a register on the read clock. It changes only at a read-clock rising edge and, once the pointers have crossed domains, equals (stored words <= empty offset).
- R4: In the same registered mode, almost-full is a register on the write clock. It changes only at a write-clock rising edge and settles to ((2^AW - stored words) <= full offset).
- R5: When the mode pin is low during reset, both flags follow the raw pointer inputs combinationally, with no clock edge needed.
- R6: An offset load is ignored unless the write pointer equals the synchronised read pointer (queue idle).
- R7: An accepted load writes the empty offset when the select bit is 0 and the full offset when it is 1. The other offset keeps its value.
- R8: A new reset restores both offsets to the default chosen by the select pins.
- R9: Changes on the mode and select pins after reset is released have no effect on either flag.
- R10: The thresholds are inclusive. Almost-empty is high at exactly n stored words and low at n+1. Almost-full is high at exactly m free words and low at m+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, shared by both domains |
| cfg_sync_i | input | 1 | Flag timing mode sampled in reset: 1 registered, 0 direct |
| cfg_sel_i | input | 2 | Default offset select sampled in reset |
| wptr_i | input | AW+1 | Binary write pointer, write domain |
| rptr_i | input | AW+1 | Binary read pointer, read domain |
| ld_en_i | input | 1 | Offset load strobe, write domain |
| ld_full_i | input | 1 | Load target: 0 empty offset, 1 full offset |
| ld_val_i | input | AW | Offset value to load |
| almost_empty_o | output | 1 | Almost-empty flag |
| almost_full_o | output | 1 | Almost-full flag |

## Verification
The assertions take three things for granted about the inputs:
- The configuration pins hold steady for at least one write-clock edge while reset is low.
- Reset is low from time zero.
- Each load strobe lasts one write-clock cycle.

The stimulus holds reset for four cycles, with the pins set before reset falls. It changes pointers and strobes only on the write-clock falling edge, which is never a rising edge of either clock. Flag values are then compared only after enough cycles for the Gray-coded pointers to cross and the flag flop to update. The direct-mode and edge-timing checks are the exception: they sample one nanosecond after a pointer change, before any rising edge.

// File: rtl/pafu_pkg.sv
package pafu_pkg;

    typedef enum logic [1:0] {
        OFS_CAPTURE = 2'd0,
        OFS_DEFAULT = 2'd1,
        OFS_CUSTOM  = 2'd2
    } ofs_state_e;

    // default threshold for a reset-time select code
    function automatic logic [9:0] dflt_offset(input logic [1:0] sel);
        logic [9:0] v;
        unique case (sel)
            2'b00:   v = 10'd1023;
            2'b01:   v = 10'd127;
            2'b10:   v = 10'd63;
            default: v = 10'd7;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pafu_ptr_sync.sv
module pafu_ptr_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);

    logic [W-1:0]             gray_q;
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             gray_dst;

    // register Gray form in source domain
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin ^ (src_bin >> 1);
    end

    // synchroniser chain in destination domain
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= gray_q;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign gray_dst = chain_q[STAGES-1];

    // Gray back to binary
    always_comb begin
        dst_bin[W-1] = gray_dst[W-1];
        for (int i = W - 2; i >= 0; i--) dst_bin[i] = dst_bin[i+1] ^ gray_dst[i];
    end

endmodule

// File: rtl/pafu_offset_ctl.sv
module pafu_offset_ctl
    import pafu_pkg::*;
#(
    parameter int OW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_pin,
    input  logic          idle,
    input  logic          ld_en,
    input  logic          ld_full,
    input  logic [OW-1:0] ld_val,
    output logic [OW-1:0] ofs_n,
    output logic [OW-1:0] ofs_m
);

    ofs_state_e    state_q, state_d;
    logic          accept;
    logic [OW-1:0] dflt;

    assign dflt   = OW'(dflt_offset(sel_pin));
    assign accept = ld_en && idle && (state_q != OFS_CAPTURE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OFS_CAPTURE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OFS_CAPTURE: state_d = OFS_DEFAULT;
            OFS_DEFAULT: if (accept) state_d = OFS_CUSTOM;
            OFS_CUSTOM:  state_d = OFS_CUSTOM;
            default:     state_d = OFS_CAPTURE;
        endcase
    end

    // outputs: threshold registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_n <= dflt;
            ofs_m <= dflt;
        end else if (accept) begin
            if (ld_full) ofs_m <= ld_val;
            else         ofs_n <= ld_val;
        end
    end

    a_r6_busy_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(ofs_n) && $stable(ofs_m)));

    a_r9_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> ($stable(ofs_n) && $stable(ofs_m)));

    a_r7_custom_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OFS_DEFAULT && !(ld_en && idle)) |=> (state_q == OFS_DEFAULT));

endmodule

// File: rtl/pafu_flag_gen.sv
module pafu_flag_gen #(
    parameter int AW   = 10,
    parameter bit FULL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic [AW:0]   cnt_sync,
    input  logic [AW:0]   cnt_raw,
    input  logic [AW-1:0] ofs,
    output logic          flag_o
);

    localparam logic [AW:0] DEPTH_C   = {1'b1, {AW{1'b0}}};
    localparam logic        RESET_VAL = !FULL;

    logic mode_q;
    logic flag_q;
    logic hit_sync;
    logic hit_raw;

    generate
        if (FULL) begin : g_full
            assign hit_sync = (DEPTH_C - cnt_sync) <= {1'b0, ofs};
            assign hit_raw  = (DEPTH_C - cnt_raw)  <= {1'b0, ofs};
        end else begin : g_empty
            assign hit_sync = cnt_sync <= {1'b0, ofs};
            assign hit_raw  = cnt_raw  <= {1'b0, ofs};
        end
    endgenerate

    // timing mode held from reset
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RESET_VAL;
        else        flag_q <= hit_sync;
    end

    assign flag_o = !rst_n ? RESET_VAL : (mode_q ? flag_q : hit_raw);

endmodule

// File: rtl/pafu_flags.sv
module pafu_flags #(
    parameter int AW     = 10,
    parameter int STAGES = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          cfg_sync_i,
    input  logic [1:0]    cfg_sel_i,
    input  logic [AW:0]   wptr_i,
    input  logic [AW:0]   rptr_i,
    input  logic          ld_en_i,
    input  logic          ld_full_i,
    input  logic [AW-1:0] ld_val_i,
    output logic          almost_empty_o,
    output logic          almost_full_o
);

    localparam int          CW      = AW + 1;
    localparam logic [AW:0] DEPTH_C = {1'b1, {AW{1'b0}}};

    logic [CW-1:0] wbin_r, rbin_w;
    logic [CW-1:0] rcount, wcount, raw_count;
    logic [AW-1:0] ofs_n, ofs_m;
    logic          idle_w;
    logic          mode_w;

    pafu_ptr_sync #(.W(CW), .STAGES(STAGES)) u_w2r (
        .src_clk(wclk), .src_rst_n(rst_n), .src_bin(wptr_i),
        .dst_clk(rclk), .dst_rst_n(rst_n), .dst_bin(wbin_r)
    );

    pafu_ptr_sync #(.W(CW), .STAGES(STAGES)) u_r2w (
        .src_clk(rclk), .src_rst_n(rst_n), .src_bin(rptr_i),
        .dst_clk(wclk), .dst_rst_n(rst_n), .dst_bin(rbin_w)
    );

    assign rcount    = wbin_r - rptr_i;
    assign wcount    = wptr_i - rbin_w;
    assign raw_count = wptr_i - rptr_i;
    assign idle_w    = (wptr_i == rbin_w);

    pafu_offset_ctl #(.OW(AW)) u_ofs (
        .clk(wclk), .rst_n(rst_n), .sel_pin(cfg_sel_i), .idle(idle_w),
        .ld_en(ld_en_i), .ld_full(ld_full_i), .ld_val(ld_val_i),
        .ofs_n(ofs_n), .ofs_m(ofs_m)
    );

    pafu_flag_gen #(.AW(AW), .FULL(1'b0)) u_ae (
        .clk(rclk), .rst_n(rst_n), .mode_pin(cfg_sync_i),
        .cnt_sync(rcount), .cnt_raw(raw_count), .ofs(ofs_n),
        .flag_o(almost_empty_o)
    );

    pafu_flag_gen #(.AW(AW), .FULL(1'b1)) u_af (
        .clk(wclk), .rst_n(rst_n), .mode_pin(cfg_sync_i),
        .cnt_sync(wcount), .cnt_raw(raw_count), .ofs(ofs_m),
        .flag_o(almost_full_o)
    );

    // mode copy seen by the write-domain checks
    always_ff @(posedge wclk) begin
        if (!rst_n) mode_w <= cfg_sync_i;
    end

    a_r2_reset_flags: assert property (@(posedge rclk)
        !rst_n |-> (almost_empty_o && !almost_full_o));

    a_r3_drained_sets_ae: assert property (@(posedge rclk) disable iff (!rst_n)
        (u_ae.mode_q && rcount == '0) |=> almost_empty_o);

    a_r4_filled_sets_af: assert property (@(posedge wclk) disable iff (!rst_n)
        (mode_w && wcount == DEPTH_C) |=> almost_full_o);

endmodule

// File: tb/pafu_flags_bench.sv
`timescale 1ns/1ps
module pafu_flags_bench;

    localparam int AW    = 10;
    localparam int CW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sync = 1'b1;
    logic [1:0]    cfg_sel = 2'b11;
    logic [CW-1:0] wptr = '0;
    logic [CW-1:0] rptr = '0;
    logic          ld_en = 1'b0;
    logic          ld_full = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic          ae, af;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    pafu_flags #(.AW(AW)) u_pafu_flags (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .cfg_sync_i(cfg_sync), .cfg_sel_i(cfg_sel),
        .wptr_i(wptr), .rptr_i(rptr),
        .ld_en_i(ld_en), .ld_full_i(ld_full), .ld_val_i(ld_val),
        .almost_empty_o(ae), .almost_full_o(af)
    );

    always #4 wclk = ~wclk;
    initial begin
        #1;
        forever #4 rclk = ~rclk;
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge wclk);
    endtask

    task automatic set_cnt(input int base, input int cnt);
        @(negedge wclk);
        rptr = CW'(base);
        wptr = CW'(base + cnt);
    endtask

    task automatic do_reset(input logic mode, input logic [1:0] sel);
        @(negedge wclk);
        rst_n = 1'b0;
        cfg_sync = mode;
        cfg_sel = sel;
        wptr = '0;
        rptr = '0;
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic load(input logic full, input int val);
        @(negedge wclk);
        ld_en = 1'b1;
        ld_full = full;
        ld_val = AW'(val);
        @(negedge wclk);
        ld_en = 1'b0;
    endtask

    // R2: flags forced during reset, even with a near-full raw count
    task automatic t_reset();
        cfg_sync = 1'b0;
        cfg_sel = 2'b11;
        wptr = CW'(1020);
        rptr = '0;
        repeat (4) @(negedge wclk);
        check("R2 ae in reset", ae, 1'b1);
        check("R2 af in reset", af, 1'b0);
        do_reset(1'b1, 2'b11);
        check("R2 ae after release", ae, 1'b1);
        check("R2 af after release", af, 1'b0);
    endtask

    // R1 and R10: each default code, inclusive thresholds
    task automatic t_defaults();
        int dv [4] = '{1023, 127, 63, 7};
        for (int s = 0; s < 4; s++) begin
            int n = dv[s];
            int base = (s == 2) ? 2000 : 0;
            do_reset(1'b1, 2'(s));
            set_cnt(base, n);     settle(); check("R1 R10 ae at n", ae, 1'b1);
            set_cnt(base, n + 1); settle(); check("R1 R10 ae at n+1", ae, 1'b0);
            set_cnt(base, DEPTH - n);     settle(); check("R1 R10 af at m free", af, 1'b1);
            set_cnt(base, DEPTH - n - 1); settle(); check("R1 R10 af at m+1 free", af, 1'b0);
        end
    endtask

    // R3 and R4: registered flags wait for their clock edge
    task automatic t_sync_timing();
        do_reset(1'b1, 2'b11);
        set_cnt(0, 20);
        #1 check("R3 ae holds before read edge", ae, 1'b1);
        settle();
        check("R3 ae after sync", ae, 1'b0);
        set_cnt(0, 1020);
        #1 check("R4 af holds before write edge", af, 1'b0);
        settle();
        check("R4 af after sync", af, 1'b1);
    endtask

    // R5: direct decode without a clock edge
    task automatic t_async();
        do_reset(1'b0, 2'b11);
        set_cnt(0, 20);
        #1 check("R5 ae direct low", ae, 1'b0);
        set_cnt(0, 1020);
        #1 check("R5 af direct high", af, 1'b1);
        set_cnt(0, 3);
        #1 check("R5 ae direct high", ae, 1'b1);
        check("R5 af direct low", af, 1'b0);
    endtask

    // R6 and R7: loads only when idle, per-flag target
    task automatic t_load();
        do_reset(1'b1, 2'b11);
        set_cnt(0, 5); settle();
        load(1'b0, 3); settle();
        check("R6 busy empty load ignored", ae, 1'b1);
        set_cnt(5, 0); settle();
        load(1'b0, 3); settle();
        set_cnt(5, 4); settle(); check("R7 loaded n above", ae, 1'b0);
        set_cnt(5, 3); settle(); check("R7 loaded n at", ae, 1'b1);
        set_cnt(5, DEPTH - 7); settle(); check("R7 full offset kept default", af, 1'b1);
        set_cnt(5, DEPTH - 8); settle(); check("R7 full offset kept default +1", af, 1'b0);
        load(1'b1, 100); settle();
        check("R6 busy full load ignored", af, 1'b0);
        set_cnt(9, 0); settle();
        load(1'b1, 100); settle();
        set_cnt(9, DEPTH - 100); settle(); check("R7 loaded m at", af, 1'b1);
        set_cnt(9, DEPTH - 101); settle(); check("R7 loaded m above", af, 1'b0);
    endtask

    // R8: reset brings defaults back
    task automatic t_restore();
        do_reset(1'b1, 2'b11);
        set_cnt(0, 5); settle(); check("R8 default n restored", ae, 1'b1);
        set_cnt(0, 8); settle(); check("R8 default n restored +1", ae, 1'b0);
    endtask

    // R9: pin changes after release do nothing
    task automatic t_pins_ignored();
        do_reset(1'b1, 2'b11);
        @(negedge wclk);
        cfg_sel = 2'b00;
        cfg_sync = 1'b0;
        set_cnt(0, 8); settle();
        check("R9 select ignored", ae, 1'b0);
        set_cnt(0, 3);
        #1 check("R9 mode ignored", ae, 1'b0);
        settle();
        check("R9 registered update", ae, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_sync_timing();
        t_async();
        t_load();
        t_restore();
        t_pins_ignored();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge wclk);
        total++;
        fails++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        finish_run();
    end

endmodule